// File: doc/BRIEF.md
# Timer Compare Match Output Unit

This unit watches an externally supplied free-running timer value and compares it against a programmable compare value. When the two become equal, it carries out the action chosen by a 4-bit mode code. The action can toggle the output pin, force it high, force it low, raise only the interrupt flag, or issue a special event. The special event asks the external timer to restart and, when the converter is enabled, starts an analog conversion.

The interrupt flag is sticky and is cleared through a dedicated clear input. The timer-reset request and the conversion-start request are single-cycle pulses. A match acts once per equality episode, so a stalled timer that keeps holding the compare value does not fire again. Mode 0000 turns the unit off. All other codes that do not name a compare action leave the unit idle.

Top module: `cmp_match_unit`

## Requirements
- R1: An action fires only on the first clock edge at which `timer_i` equals `cmp_val_i` after a cycle of inequality, or on the first edge after reset. While the equality persists, no further action fires. Equality that is present when a compare mode is entered does not fire.
- R2: In mode 4'b0010, each match inverts `pin_o`.
- R3: In mode 4'b1000, the first edge after the mode is entered drives `pin_o` low, and a match drives it high.
- R4: In mode 4'b1001, the first edge after the mode is entered drives `pin_o` high, and a match drives it low.
- R5: In mode 4'b1010, a match sets `flag_o` and leaves `pin_o` unchanged.
- R6: In mode 4'b1011, a match sets `flag_o` and raises `tmr_rst_o` for exactly one cycle. `adc_start_o` is raised in that same cycle only if `adc_en_i` is 1. In every other mode, both pulses stay 0.
- R7: In each of the five compare modes, a match sets `flag_o`. The flag stays set until `flag_clr_i` is 1 at an edge with no match. A match wins over a simultaneous clear.
- R8: In mode 4'b0000, one edge drives `pin_o` and `flag_o` to 0, and no pulses are issued.
- R9: Codes other than 0000, 0010, 1000, 1001, 1010 and 1011 hold `pin_o`. They never set `flag_o` and never issue pulses. `flag_clr_i` still clears the flag in these codes.
- R10: While `rst` is high, all outputs are 0. Every output is registered, so the effect of a match appears at the clock edge where the equality is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 4 | Match action code |
| cmp_val_i | input | TW (16) | Compare value |
| timer_i | input | TW (16) | External timer value |
| adc_en_i | input | 1 | Converter enabled |
| flag_clr_i | input | 1 | Clears the sticky flag |
| pin_o | output | 1 | Compare output pin |
| flag_o | output | 1 | Sticky interrupt flag |
| tmr_rst_o | output | 1 | One-cycle timer restart request |
| adc_start_o | output | 1 | One-cycle conversion start request |

## Verification
Suppose the stored previous-equality bit is wrong. Then a stalled timer either fires a second action at the very next edge, or a genuine new episode is lost. Either fault shows on `pin_o` or on the pulse outputs one cycle after the bad sample.

Suppose the remembered mode is wrong. Then the set and clear presets appear on the wrong cycle, or not at all. That shows on `pin_o` at the first edge after a mode change.

Suppose the sticky flag is corrupted. It differs from the expected value at the next edge and stays wrong until the next clear or match. That makes a cycle-by-cycle comparison across every mode code sufficient to expose it.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef logic [3:0] mode_t;

  localparam mode_t MD_OFF    = 4'b0000;
  localparam mode_t MD_TOGGLE = 4'b0010;
  localparam mode_t MD_HIGH   = 4'b1000;
  localparam mode_t MD_LOW    = 4'b1001;
  localparam mode_t MD_IRQ    = 4'b1010;
  localparam mode_t MD_EVENT  = 4'b1011;

  // decoded action set for the current mode code
  typedef struct packed {
    logic off;      // unit disabled, state cleared
    logic cmp_on;   // one of the five compare modes
    logic tog;      // invert pin on match
    logic hi;       // drive pin high on match
    logic lo;       // drive pin low on match
    logic evt;      // special event on match
  } act_t;
endpackage

// File: rtl/cmp_eq_detect.sv
module cmp_eq_detect #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tmr_i,
  input  logic [TW-1:0] ref_i,
  output logic          hit_o
);
  logic eq;
  logic eq_q;

  assign eq    = (tmr_i == ref_i);
  assign hit_o = eq & ~eq_q;

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

  // a hit cannot repeat on the next cycle
  assert_one_shot_R1: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o);
endmodule

// File: rtl/cmp_mode_decode.sv
module cmp_mode_decode
  import cmp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode_i,
  output act_t  act_o,
  output logic  enter_o
);
  mode_t mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MD_OFF;
    else     mode_q <= mode_i;
  end

  assign enter_o = (mode_i != mode_q);

  always_comb begin
    act_o = '0;
    unique case (mode_i)
      MD_OFF:    act_o.off = 1'b1;
      MD_TOGGLE: begin act_o.cmp_on = 1'b1; act_o.tog = 1'b1; end
      MD_HIGH:   begin act_o.cmp_on = 1'b1; act_o.hi  = 1'b1; end
      MD_LOW:    begin act_o.cmp_on = 1'b1; act_o.lo  = 1'b1; end
      MD_IRQ:    act_o.cmp_on = 1'b1;
      MD_EVENT:  begin act_o.cmp_on = 1'b1; act_o.evt = 1'b1; end
      default:   act_o = '0;
    endcase
  end

  assert_decode_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({act_o.tog, act_o.hi, act_o.lo, act_o.evt}));
endmodule

// File: rtl/cmp_action.sv
module cmp_action
  import cmp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  act_t act_i,
  input  logic enter_i,
  input  logic hit_i,
  input  logic adc_en_i,
  input  logic flag_clr_i,
  output logic pin_o,
  output logic flag_o,
  output logic tmr_rst_o,
  output logic adc_start_o
);
  logic fire;
  logic pin_d;
  logic flag_d;

  assign fire = hit_i & act_i.cmp_on;

  always_comb begin
    pin_d = pin_o;
    if (act_i.off)                 pin_d = 1'b0;
    else if (fire && act_i.tog)    pin_d = ~pin_o;
    else if (fire && act_i.hi)     pin_d = 1'b1;
    else if (fire && act_i.lo)     pin_d = 1'b0;
    else if (enter_i && act_i.hi)  pin_d = 1'b0;
    else if (enter_i && act_i.lo)  pin_d = 1'b1;
  end

  always_comb begin
    flag_d = flag_o;
    if (act_i.off)       flag_d = 1'b0;
    else if (fire)       flag_d = 1'b1;
    else if (flag_clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o       <= 1'b0;
      flag_o      <= 1'b0;
      tmr_rst_o   <= 1'b0;
      adc_start_o <= 1'b0;
    end else begin
      pin_o       <= pin_d;
      flag_o      <= flag_d;
      tmr_rst_o   <= fire & act_i.evt;
      adc_start_o <= fire & act_i.evt & adc_en_i;
    end
  end

  assert_high_on_match_R3: assert property (@(posedge clk) disable iff (rst)
    (fire && act_i.hi) |=> pin_o);
  assert_low_on_match_R4: assert property (@(posedge clk) disable iff (rst)
    (fire && act_i.lo) |=> !pin_o);
  assert_irq_pin_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (act_i.cmp_on && !act_i.tog && !act_i.hi && !act_i.lo) |=> $stable(pin_o));
  assert_start_needs_restart_R6: assert property (@(posedge clk) disable iff (rst)
    adc_start_o |-> tmr_rst_o);
  assert_restart_single_R6: assert property (@(posedge clk) disable iff (rst)
    tmr_rst_o |=> !tmr_rst_o);
  assert_flag_on_match_R7: assert property (@(posedge clk) disable iff (rst)
    fire |=> flag_o);
  assert_off_clears_R8: assert property (@(posedge clk) disable iff (rst)
    act_i.off |=> (!pin_o && !flag_o && !tmr_rst_o));
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmp_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    mode_i,
  input  logic [TW-1:0] cmp_val_i,
  input  logic [TW-1:0] timer_i,
  input  logic          adc_en_i,
  input  logic          flag_clr_i,
  output logic          pin_o,
  output logic          flag_o,
  output logic          tmr_rst_o,
  output logic          adc_start_o
);
  logic hit;
  logic enter;
  act_t act;

  cmp_eq_detect #(.TW(TW)) u_eq (
    .clk   (clk),
    .rst   (rst),
    .tmr_i (timer_i),
    .ref_i (cmp_val_i),
    .hit_o (hit)
  );

  cmp_mode_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode_i),
    .act_o   (act),
    .enter_o (enter)
  );

  cmp_action u_act (
    .clk         (clk),
    .rst         (rst),
    .act_i       (act),
    .enter_i     (enter),
    .hit_i       (hit),
    .adc_en_i    (adc_en_i),
    .flag_clr_i  (flag_clr_i),
    .pin_o       (pin_o),
    .flag_o      (flag_o),
    .tmr_rst_o   (tmr_rst_o),
    .adc_start_o (adc_start_o)
  );

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!pin_o && !flag_o && !tmr_rst_o && !adc_start_o));
endmodule

// File: tb/test_cmp_match_unit.sv
module test_cmp_match_unit;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    mode_i;
  logic [TW-1:0] cmp_val_i;
  logic [TW-1:0] timer_i;
  logic          adc_en_i;
  logic          flag_clr_i;
  logic          pin_o, flag_o, tmr_rst_o, adc_start_o;

  int total = 0;
  int bad   = 0;

  // reference state, derived from the requirement list
  logic       m_pin, m_flag, m_rst, m_adc, m_eq_prev;
  logic [3:0] m_mode_q;

  always #10 clk = ~clk;

  cmp_match_unit #(.TW(TW)) i_cmp_match_unit (
    .clk(clk), .rst(rst), .mode_i(mode_i), .cmp_val_i(cmp_val_i),
    .timer_i(timer_i), .adc_en_i(adc_en_i), .flag_clr_i(flag_clr_i),
    .pin_o(pin_o), .flag_o(flag_o), .tmr_rst_o(tmr_rst_o),
    .adc_start_o(adc_start_o)
  );

  function automatic string pin_req(input logic [3:0] m);
    case (m)
      4'b0000: return "R8";
      4'b0010: return "R2";
      4'b1000: return "R3";
      4'b1001: return "R4";
      4'b1010: return "R5";
      4'b1011: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b (mode=%b timer=%0d cmp=%0d t=%0t)",
               req, act, exp, mode_i, timer_i, cmp_val_i, $time);
    end
  endtask

  // advance the model by one edge using the inputs now applied
  task automatic model_step();
    logic eq, hit, cmpm, fire, enter;
    eq    = (timer_i == cmp_val_i);
    hit   = eq && !m_eq_prev;
    m_eq_prev = eq;
    cmpm  = (mode_i == 4'b0010) || (mode_i == 4'b1000) || (mode_i == 4'b1001) ||
            (mode_i == 4'b1010) || (mode_i == 4'b1011);
    fire  = hit && cmpm;
    enter = (mode_i != m_mode_q);
    m_mode_q = mode_i;
    if (mode_i == 4'b0000) begin
      m_pin = 1'b0; m_flag = 1'b0;
    end else begin
      if (fire && mode_i == 4'b0010)       m_pin = ~m_pin;
      else if (fire && mode_i == 4'b1000)  m_pin = 1'b1;
      else if (fire && mode_i == 4'b1001)  m_pin = 1'b0;
      else if (enter && mode_i == 4'b1000) m_pin = 1'b0;
      else if (enter && mode_i == 4'b1001) m_pin = 1'b1;
      if (fire)            m_flag = 1'b1;
      else if (flag_clr_i) m_flag = 1'b0;
    end
    m_rst = fire && (mode_i == 4'b1011);
    m_adc = m_rst && adc_en_i;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #2;
    // every output is compared at the edge the match is sampled (R1, R10)
    check({pin_req(mode_i), "/R1 pin"}, pin_o, m_pin);
    check((mode_i == 4'b0000) ? "R8 flag" : "R7 flag", flag_o, m_flag);
    check("R6 tmr_rst", tmr_rst_o, m_rst);
    check("R6 adc_start", adc_start_o, m_adc);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; mode_i = 4'b0000; cmp_val_i = 16'd5; timer_i = 16'd0;
    adc_en_i = 1'b0; flag_clr_i = 1'b0;
    m_pin = 0; m_flag = 0; m_rst = 0; m_adc = 0; m_eq_prev = 0; m_mode_q = 4'b0000;
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    check("R10 pin", pin_o, 1'b0);
    check("R10 flag", flag_o, 1'b0);
    check("R10 tmr_rst", tmr_rst_o, 1'b0);
    check("R10 adc_start", adc_start_o, 1'b0);
    rst = 1'b0;

    // sweep every mode code and several compare values;
    // the timer ramps, stalls on the compare value (R1) and wraps
    for (int pass = 0; pass < 2; pass++) begin
      for (int md = 0; md < 16; md++) begin
        for (int cv = 2; cv < 11; cv += 4) begin
          mode_i    = 4'(md);
          cmp_val_i = 16'(cv);
          adc_en_i  = ((md + cv + pass) % 2) == 0;
          for (int rep = 0; rep < 3; rep++) begin
            for (int t = 0; t < 12; t++) begin
              timer_i    = 16'(t);
              flag_clr_i = (t == 1) && (rep == 1);
              tick();
              if (t == cv) begin
                for (int s = 0; s < 3; s++) tick();   // stalled timer
              end
            end
          end
          // clear coincident with a match: match wins (R7)
          timer_i = 16'd0; flag_clr_i = 1'b0; tick();
          timer_i = 16'(cv); flag_clr_i = 1'b1; tick();
          flag_clr_i = 1'b0;
        end
      end
      // change mode while the timer holds equality: no fire (R1)
      mode_i = 4'b0101; timer_i = cmp_val_i; tick(); tick();
      mode_i = 4'b1011; tick(); tick();
      mode_i = 4'b1000; tick();
      mode_i = 4'b1001; tick();
    end

    // directed: entering set mode then one match (R3)
    mode_i = 4'b0000; timer_i = 16'd0; cmp_val_i = 16'd3; tick();
    mode_i = 4'b1001; tick();
    check("R4 preset high", pin_o, 1'b1);
    mode_i = 4'b1000; tick();
    check("R3 preset low", pin_o, 1'b0);
    timer_i = 16'd3; tick();
    check("R3 match high", pin_o, 1'b1);
    // event without converter enable (R6)
    mode_i = 4'b1011; adc_en_i = 1'b0; timer_i = 16'd0; tick();
    timer_i = 16'd3; tick();
    check("R6 restart pulse", tmr_rst_o, 1'b1);
    check("R6 no start when disabled", adc_start_o, 1'b0);
    tick();
    check("R6 pulse ends", tmr_rst_o, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule